// File: doc/BRIEF.md
# Video Core Power-Down Sequencer

This block takes a multi-pipe video core through an orderly shutdown. After a start pulse it first looks at the core's power-on flag. If the core is already collapsed, it goes straight to the power-off request. If not, it forces the core clock to run when the clock configuration is nonzero. It then polls each pixel pipe's idle flag in index order and quiesces the interconnect. Next it releases the core bridge through a three-step reset pattern, and finally raises the power-off request.

Two interconnect quiesce styles are supported, chosen by a mode input that is held for the whole run. In the first style, a two-bit reset request is raised and then dropped again, with the acknowledge observed going up and coming back down. In the second style, a low-power status flag is awaited and then a low-power request is asserted. Every polled wait counts time in pulses of an external tick input. The pipe waits use one poll interval and timeout pair, and the interconnect waits use a shorter pair. Any timeout abandons the remaining steps, jumps to the power-off request and leaves an error flag set.

Top module: `vpd_seq`

## Requirements
- R1: When `coreOn` is 0 at the check after start, the sequencer emits no clock-run write, no interconnect request and no bridge reset, and ends with `pwrOffReq`=1, a `done` pulse and `err`=0.
- R2: When powered, exactly one `clkRunWr` pulse is produced if `clkCfg` is nonzero, and none if it is zero, before any pipe polling.
- R3: Pipe idle flags are awaited in order from index 0 to NPIPE-1. A pipe whose flag stays 0 until the pipe timeout ends the run with `err`=1 and without any interconnect or bridge activity.
- R4: In reset-handshake mode (`lpiMode`=0), `nocRstReq` is driven to 2'b11 until either `nocAck` bit is seen, is then cleared to 2'b00, and the sequencer waits until both `nocAck` bits are 0.
- R5: In low-power mode (`lpiMode`=1), the sequencer waits for `lpiStat`=1 and then sets `lpiReq`=1, which stays set until the next start.
- R6: The bridge reset output `bridgeRst` (bit 0 software reset, bit 1 hardware-reset disable) takes the values 2'b11, 2'b10 and 2'b00 on three consecutive cycles after the interconnect step succeeds.
- R7: A timeout in any wait skips all remaining steps to the power-off request, and `err` then stays 1 until the next start.
- R8: A condition is checked on entry to a wait and again every poll-interval ticks. A timeout is declared only once at least the timeout count of ticks has elapsed in that wait.
- R9: `done` is a single-cycle pulse at the end of every run, and a new start clears `err` and `pwrOffReq`.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a power-down run (taken while idle) |
| lpiMode | input | 1 | 0: reset handshake, 1: low-power handshake |
| tick | input | 1 | Time-base pulse for polling |
| coreOn | input | 1 | 1 when the core power is on |
| clkCfg | input | CFG_W | Current core clock configuration value |
| pipeIdle | input | NPIPE | Per-pipe idle flag |
| nocAck | input | 2 | Interconnect reset acknowledge |
| lpiStat | input | 1 | Interconnect low-power ready flag |
| clkRunWr | output | 1 | Pulse: write zero to clock configuration |
| nocRstReq | output | 2 | Interconnect reset request |
| lpiReq | output | 1 | Interconnect low-power request |
| bridgeRst | output | 2 | Bridge reset control |
| pwrOffReq | output | 1 | Final power-off request, held until next start |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Run ended by a timeout |

## Verification
The assertions assume that `lpiMode` does not change during a run and that `start` is only given while the sequencer is idle. They also assume that `nocAck` does not report an acknowledge while no request is out. The stimulus respects these limits: it sets mode and status inputs before each start, waits for `done` before starting again, and lets a small delay model echo the request back onto `nocAck` or hold it stuck. Ticks arrive every other cycle, so poll points fall on tick cycles and fresh-entry checks fall between them.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_PIPE, S_ACK, S_ACKCLR, S_LPI, S_BR1, S_BR2, S_OFF
  } state_e;

  typedef struct packed {
    logic       clrOuts;
    logic       clrTimer;
    logic       slowTimer;
    logic       pipeClr;
    logic       pipeInc;
    logic       clkRun;
    logic       reqSet;
    logic       reqClr;
    logic       lpiSet;
    logic       brWr;
    logic [1:0] brVal;
    logic       pwrOff;
    logic       doneP;
    logic       errSet;
  } strobe_t;

endpackage

// File: rtl/vpd_ctrl.sv
module vpd_ctrl
  import vpd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    lpiMode,
  input  logic    coreOn,
  input  logic    clkNonZero,
  input  logic    pipeOk,
  input  logic    lastPipe,
  input  logic    ackAny,
  input  logic    ackNone,
  input  logic    lpiOk,
  input  logic    sample,
  input  logic    expired,
  output strobe_t st
);

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    st = '0;
    stateNext = state;
    st.slowTimer = (state == S_PIPE);
    unique case (state)
      S_IDLE: begin
        if (start) begin
          st.clrOuts = 1'b1;
          stateNext = S_CHK;
        end
      end
      S_CHK: begin
        if (!coreOn) begin
          stateNext = S_OFF;
        end else begin
          st.clkRun   = clkNonZero;
          st.pipeClr  = 1'b1;
          st.clrTimer = 1'b1;
          stateNext   = S_PIPE;
        end
      end
      S_PIPE: begin
        if (sample && pipeOk) begin
          st.clrTimer = 1'b1;
          if (!lastPipe) begin
            st.pipeInc = 1'b1;
          end else if (lpiMode) begin
            stateNext = S_LPI;
          end else begin
            st.reqSet = 1'b1;
            stateNext = S_ACK;
          end
        end else if (sample && expired) begin
          st.errSet = 1'b1;
          stateNext = S_OFF;
        end
      end
      S_ACK: begin
        if (sample && ackAny) begin
          st.reqClr   = 1'b1;
          st.clrTimer = 1'b1;
          stateNext   = S_ACKCLR;
        end else if (sample && expired) begin
          st.errSet = 1'b1;
          stateNext = S_OFF;
        end
      end
      S_ACKCLR: begin
        if (sample && ackNone) begin
          st.brWr   = 1'b1;
          st.brVal  = 2'b11;
          stateNext = S_BR1;
        end else if (sample && expired) begin
          st.errSet = 1'b1;
          stateNext = S_OFF;
        end
      end
      S_LPI: begin
        if (sample && lpiOk) begin
          st.lpiSet = 1'b1;
          st.brWr   = 1'b1;
          st.brVal  = 2'b11;
          stateNext = S_BR1;
        end else if (sample && expired) begin
          st.errSet = 1'b1;
          stateNext = S_OFF;
        end
      end
      S_BR1: begin
        st.brWr   = 1'b1;
        st.brVal  = 2'b10;
        stateNext = S_BR2;
      end
      S_BR2: begin
        st.brWr   = 1'b1;
        st.brVal  = 2'b00;
        stateNext = S_OFF;
      end
      S_OFF: begin
        st.pwrOff = 1'b1;
        st.doneP  = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R1: a collapsed core goes straight to power-off
  p_collapsed_skip_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHK && !coreOn) |=> (state == S_OFF));

  // R7: an expired wait without its condition leads to power-off next
  p_timeout_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ACK && sample && !ackAny && expired) |=> (state == S_OFF));

endmodule

// File: rtl/vpd_dp.sv
module vpd_dp
  import vpd_pkg::*;
#(
  parameter int NPIPE     = 2,
  parameter int IDLE_POLL = 2000,
  parameter int IDLE_TO   = 20000,
  parameter int HS_POLL   = 200,
  parameter int HS_TO     = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [NPIPE-1:0] pipeIdle,
  input  strobe_t          st,
  output logic             sample,
  output logic             expired,
  output logic             pipeOk,
  output logic             lastPipe,
  output logic             clkRunWr,
  output logic [1:0]       nocRstReq,
  output logic             lpiReq,
  output logic [1:0]       bridgeRst,
  output logic             pwrOffReq,
  output logic             done,
  output logic             err
);

  localparam int MAX_TO   = (IDLE_TO > HS_TO) ? IDLE_TO : HS_TO;
  localparam int MAX_POLL = (IDLE_POLL > HS_POLL) ? IDLE_POLL : HS_POLL;
  localparam int EL_W     = $clog2(MAX_TO + 2);
  localparam int PC_W     = $clog2(MAX_POLL + 1);
  localparam int PI_W     = (NPIPE > 1) ? $clog2(NPIPE) : 1;

  logic [EL_W-1:0] elapsed;
  logic [PC_W-1:0] pollCnt;
  logic            fresh;
  logic [PI_W-1:0] pipeIdx;
  logic [PC_W-1:0] pollLast;
  logic [EL_W:0]   curTo;
  logic [EL_W:0]   elapsedNext;
  logic            pollDue;
  logic            pipeSel [NPIPE];

  assign pollLast    = st.slowTimer ? PC_W'(IDLE_POLL - 1) : PC_W'(HS_POLL - 1);
  assign curTo       = st.slowTimer ? (EL_W+1)'(IDLE_TO) : (EL_W+1)'(HS_TO);
  assign elapsedNext = {1'b0, elapsed} + (EL_W+1)'(tick);
  assign pollDue     = tick && (pollCnt == pollLast);
  assign sample      = fresh || pollDue;
  assign expired     = elapsedNext >= curTo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= '0;
      pollCnt <= '0;
      fresh   <= 1'b0;
    end else if (st.clrTimer) begin
      elapsed <= '0;
      pollCnt <= '0;
      fresh   <= 1'b1;
    end else begin
      fresh <= 1'b0;
      if (tick) begin
        if ({1'b0, elapsed} < curTo) elapsed <= elapsed + 1'b1;
        pollCnt <= pollDue ? '0 : pollCnt + 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < NPIPE; g++) begin : g_pipe
      assign pipeSel[g] = pipeIdle[g];
    end
  endgenerate

  assign pipeOk   = pipeSel[pipeIdx];
  assign lastPipe = (pipeIdx == PI_W'(NPIPE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           pipeIdx <= '0;
    else if (st.pipeClr) pipeIdx <= '0;
    else if (st.pipeInc) pipeIdx <= pipeIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkRunWr  <= 1'b0;
      nocRstReq <= 2'b00;
      lpiReq    <= 1'b0;
      bridgeRst <= 2'b00;
      pwrOffReq <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      clkRunWr <= st.clkRun;
      done     <= st.doneP;
      if (st.clrOuts || st.reqClr) nocRstReq <= 2'b00;
      else if (st.reqSet)          nocRstReq <= 2'b11;
      if (st.clrOuts)     lpiReq <= 1'b0;
      else if (st.lpiSet) lpiReq <= 1'b1;
      if (st.clrOuts)   bridgeRst <= 2'b00;
      else if (st.brWr) bridgeRst <= st.brVal;
      if (st.clrOuts)     pwrOffReq <= 1'b0;
      else if (st.pwrOff) pwrOffReq <= 1'b1;
      if (st.clrOuts)     err <= 1'b0;
      else if (st.errSet) err <= 1'b1;
    end
  end

  // R6: bridge release steps follow each other on consecutive cycles
  p_bridge_step1_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeRst == 2'b11) |=> (bridgeRst == 2'b10));
  p_bridge_step2_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bridgeRst == 2'b10) |=> (bridgeRst == 2'b00));

  // R2: clock-run write is a single pulse
  p_clkrun_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkRunWr |=> !clkRunWr);

  // R9: done lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: an error flag comes just ahead of the power-off request
  p_err_leads_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(err) |=> (pwrOffReq && done));

  // R3: pipe index never leaves its range
  p_pipe_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(pipeIdx) < NPIPE));

endmodule

// File: rtl/vpd_seq.sv
module vpd_seq
  import vpd_pkg::*;
#(
  parameter int NPIPE     = 2,
  parameter int CFG_W     = 32,
  parameter int IDLE_POLL = 2000,
  parameter int IDLE_TO   = 20000,
  parameter int HS_POLL   = 200,
  parameter int HS_TO     = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             lpiMode,
  input  logic             tick,
  input  logic             coreOn,
  input  logic [CFG_W-1:0] clkCfg,
  input  logic [NPIPE-1:0] pipeIdle,
  input  logic [1:0]       nocAck,
  input  logic             lpiStat,
  output logic             clkRunWr,
  output logic [1:0]       nocRstReq,
  output logic             lpiReq,
  output logic [1:0]       bridgeRst,
  output logic             pwrOffReq,
  output logic             done,
  output logic             err
);

  strobe_t st;
  logic sample, expired, pipeOk, lastPipe;

  vpd_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .lpiMode    (lpiMode),
    .coreOn     (coreOn),
    .clkNonZero (|clkCfg),
    .pipeOk     (pipeOk),
    .lastPipe   (lastPipe),
    .ackAny     (|nocAck),
    .ackNone    (nocAck == 2'b00),
    .lpiOk      (lpiStat),
    .sample     (sample),
    .expired    (expired),
    .st         (st)
  );

  vpd_dp #(
    .NPIPE     (NPIPE),
    .IDLE_POLL (IDLE_POLL),
    .IDLE_TO   (IDLE_TO),
    .HS_POLL   (HS_POLL),
    .HS_TO     (HS_TO)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .tick      (tick),
    .pipeIdle  (pipeIdle),
    .st        (st),
    .sample    (sample),
    .expired   (expired),
    .pipeOk    (pipeOk),
    .lastPipe  (lastPipe),
    .clkRunWr  (clkRunWr),
    .nocRstReq (nocRstReq),
    .lpiReq    (lpiReq),
    .bridgeRst (bridgeRst),
    .pwrOffReq (pwrOffReq),
    .done      (done),
    .err       (err)
  );

  // R4: the request only drops after an acknowledge was seen
  p_req_drop_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(nocRstReq[0]) && !done) |-> $past(|nocAck));

  // R5: the low-power request only rises after the ready flag
  p_lpi_after_stat_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lpiReq) |-> $past(lpiStat));

endmodule

// File: tb/vpd_seq_tb_top.sv
module vpd_seq_tb_top;

  localparam int NP   = 3;
  localparam int CW   = 8;
  localparam int IP   = 3;
  localparam int ITO  = 12;
  localparam int HP   = 2;
  localparam int HTO  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, lpiMode = 1'b0, tick = 1'b0, coreOn = 1'b0;
  logic [CW-1:0] clkCfg = '0;
  logic [NP-1:0] pipeIdle = '0;
  logic [1:0] nocAck = 2'b00;
  logic lpiStat = 1'b0;
  logic clkRunWr, lpiReq, pwrOffReq, done, err;
  logic [1:0] nocRstReq, bridgeRst;

  always #4 clk = ~clk;

  vpd_seq #(.NPIPE(NP), .CFG_W(CW), .IDLE_POLL(IP), .IDLE_TO(ITO),
            .HS_POLL(HP), .HS_TO(HTO)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .lpiMode(lpiMode), .tick(tick),
    .coreOn(coreOn), .clkCfg(clkCfg), .pipeIdle(pipeIdle), .nocAck(nocAck),
    .lpiStat(lpiStat), .clkRunWr(clkRunWr), .nocRstReq(nocRstReq),
    .lpiReq(lpiReq), .bridgeRst(bridgeRst), .pwrOffReq(pwrOffReq),
    .done(done), .err(err));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // tick every other cycle, changing at the falling edge
  always @(negedge clk) tick = ~tick;

  // acknowledge model: 0 echo request, 1 stuck low, 2 stuck high
  int ackMode = 0;
  logic [1:0] ackD1 = 2'b00, ackD2 = 2'b00;
  always @(negedge clk) begin
    ackD2 = ackD1;
    ackD1 = nocRstReq;
    if (ackMode == 1)      nocAck = 2'b00;
    else if (ackMode == 2) nocAck = 2'b11;
    else                   nocAck = ackD2;
  end

  typedef struct {
    string name;
    bit    err;
    int    clkRuns;
    bit    reqSeen;
    bit    lpiSeen;
    bit    brSeen;
    int    minTicks;
    string req;
  } exp_t;

  exp_t expQ[$];
  bit   runActive = 1'b0;
  int   ticks, clkRuns;
  bit   reqSeen, brSeen;
  logic [1:0] brH1, brH2;

  // monitor: sample shortly after the rising edge
  always @(posedge clk) begin
    #2;
    if (runActive) begin
      if (tick) ticks++;
      if (clkRunWr) clkRuns++;
      if (nocRstReq == 2'b11) reqSeen = 1'b1;
      if (brH2 == 2'b11 && brH1 == 2'b10 && bridgeRst == 2'b00) brSeen = 1'b1;
      brH2 = brH1;
      brH1 = bridgeRst;
      if (done) begin
        exp_t e;
        e = expQ.pop_front();
        chk(err == e.err, e.req, {e.name, " err"}, err, e.err);
        chk(pwrOffReq == 1'b1, e.req, {e.name, " pwrOffReq"}, pwrOffReq, 1);
        chk(clkRuns == e.clkRuns, "R2", {e.name, " clock-run pulses"}, clkRuns, e.clkRuns);
        chk(reqSeen == e.reqSeen, e.req, {e.name, " reset request seen"}, reqSeen, e.reqSeen);
        chk(lpiReq == e.lpiSeen, e.req, {e.name, " lpiReq"}, lpiReq, e.lpiSeen);
        chk(brSeen == e.brSeen, "R6", {e.name, " bridge 11/10/00"}, brSeen, e.brSeen);
        chk(ticks >= e.minTicks, "R8", {e.name, " ticks before timeout"}, ticks, e.minTicks);
        runActive = 1'b0;
      end
    end
  end

  task automatic run(input exp_t e);
    @(negedge clk);
    expQ.push_back(e);
    ticks = 0; clkRuns = 0; reqSeen = 0; brSeen = 0;
    brH1 = 2'b00; brH2 = 2'b00;
    runActive = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b0, "R9", {e.name, " err cleared by start"}, err, 0);
    chk(pwrOffReq == 1'b0, "R9", {e.name, " pwrOffReq cleared by start"}, pwrOffReq, 0);
    for (int i = 0; i < 2000 && runActive; i++) @(negedge clk);
    chk(!runActive, e.req, {e.name, " run finished"}, runActive, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", {e.name, " done single cycle"}, done, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "ALL", "watchdog expired", cyc, 100000);
      summary();
    end
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R10: reset values
    chk({clkRunWr, nocRstReq, lpiReq, bridgeRst, pwrOffReq, done, err} == '0,
        "R10", "outputs in reset", {clkRunWr, nocRstReq, lpiReq, bridgeRst, pwrOffReq, done, err}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({clkRunWr, nocRstReq, lpiReq, bridgeRst, pwrOffReq, done, err} == '0,
        "R10", "outputs after reset", {clkRunWr, nocRstReq, lpiReq, bridgeRst, pwrOffReq, done, err}, 0);

    // R1: collapsed core, nonzero clock config must be left alone
    coreOn = 1'b0; clkCfg = 8'h5A; pipeIdle = '1; ackMode = 0; lpiMode = 1'b0;
    e = '{"collapsed", 0, 0, 0, 0, 0, 0, "R1"};
    run(e);

    // R4: reset handshake with nonzero clock config (R2 one pulse)
    coreOn = 1'b1; clkCfg = 8'h01; pipeIdle = '1; ackMode = 0; lpiMode = 1'b0;
    e = '{"reset-handshake", 0, 1, 1, 0, 1, 0, "R4"};
    run(e);

    // R5: low-power handshake with zero clock config
    clkCfg = 8'h00; lpiStat = 1'b1; lpiMode = 1'b1;
    e = '{"lpi-handshake", 0, 0, 0, 1, 1, 0, "R5"};
    run(e);

    // R3: pipe 1 never idle, pipe 2 idle is not enough
    clkCfg = 8'h80; pipeIdle = 3'b101; lpiMode = 1'b0;
    e = '{"pipe1-stuck", 1, 1, 0, 0, 0, ITO, "R3"};
    run(e);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R7", "err held after timeout", err, 1);
    chk(nocRstReq == 2'b00, "R3", "no request after pipe timeout", nocRstReq, 0);

    // R7: acknowledge never arrives
    clkCfg = 8'h00; pipeIdle = '1; ackMode = 1;
    e = '{"ack-timeout", 1, 0, 1, 0, 0, HTO, "R7"};
    run(e);

    // R4: acknowledge never clears
    ackMode = 2;
    e = '{"ack-stuck-high", 1, 0, 1, 0, 0, HTO, "R4"};
    run(e);
    chk(nocRstReq == 2'b00, "R4", "request dropped after ack", nocRstReq, 0);

    // R5: low-power status never ready
    ackMode = 0; lpiMode = 1'b1; lpiStat = 1'b0;
    e = '{"lpi-timeout", 1, 0, 0, 0, 0, HTO, "R5"};
    run(e);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, "R7", "err held after lpi timeout", err, 1);

    // R9: a clean run after an error clears the flag
    lpiStat = 1'b1;
    e = '{"lpi-recover", 0, 0, 0, 1, 1, 0, "R9"};
    run(e);

    summary();
  end

endmodule